// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them with level 0 as the highest priority, and raises a single interrupt output toward the processor. The processor answers with an acknowledge pulse. The controller then drives a vector equal to a programmed base plus the winning level, and marks that level as in service until an end-of-interrupt command releases it. If the programmed option is set, the level is released on the acknowledge itself.

Software reaches the block through two byte-wide registers on a simple bus: a command register and a data register. A command byte with bit 4 set starts a setup sequence. The data writes that follow load the vector base, an optional cascade word and an optional mode word. After setup, data writes load the mask and command writes select read-back or retire a level. A separate write strobe loads a per-level trigger register, which chooses edge or level sensitivity. Cascading itself is not built: the cascade word is only stored and exposed on a port.

Top module: `pic_core`

## Requirements
- R1: After reset, data-register reads return 0xFF (all masked), command-register reads return 0x00, the interrupt output is low, no vector is valid and the cascade word is 0x00.
- R2: A command write with bit 4 set starts setup and clears every in-service bit. The following data writes are taken as the vector base, then the cascade word (skipped when bit 1 of the start byte is 1), then the mode word (taken only when bit 0 is 1). Only after these does a data write load the mask.
- R3: One cycle after an acknowledge pulse, the vector-valid output pulses for one cycle and the vector equals base plus the granted level, modulo 256.
- R4: The cascade word from setup is presented on the cascade output unchanged until the next setup writes it.
- R5: When bit 1 of the mode word is 1, an acknowledge does not set any in-service bit.
- R6: Outside setup, a data write loads the mask and data reads return it as written. With the mask at 0xFF the interrupt output stays low whatever the requests.
- R7: Command write 0x0A selects the request register and 0x0B selects the in-service register for command reads. The choice holds until another such write or a new setup, which selects the request register.
- R8: Command write 0x60+n (n from 0 to 7) clears in-service bit n and no other bit.
- R9: An acknowledge while the interrupt output is low yields vector base+7 and leaves the in-service and request registers unchanged, even with level 7 masked.
- R10: The interrupt output is high exactly when some unmasked requested level has a smaller number than every in-service level.
- R11: An acknowledge granted to a level sets that level's in-service bit (auto-release off) and clears its request bit when the level is edge-sensitive.
- R12: With trigger bit n at 0, a rising edge on input n sets request bit n at the next clock edge, and the bit stays set after the input falls.
- R13: With trigger bit n at 1 (loaded by the trigger strobe from the write data), request bit n copies input n one clock later, and an acknowledge does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| trig_wr | input | 1 | Trigger register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_line | input | 8 | Interrupt request inputs |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
An acknowledge pulse and a specific end-of-interrupt command can reach the in-service register in the same clock. One event sets a bit and the other clears a bit. The bench arranges this by holding level 3 in service, raising level 1, and then issuing the acknowledge and the command for level 3 in the same cycle. A cycle-level reference model in the bench predicts the result, which must have only level 1 in service. The same model judges the interrupt output and the vector on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      SU_IDLE = 2'd0,
      SU_BASE = 2'd1,
      SU_CASC = 2'd2,
      SU_MODE = 2'd3
   } setup_st_e;

   localparam logic [2:0] EOI_SPECIFIC = 3'b011;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int DW    = 8,
   parameter int N_LVL = 8,
   localparam int LVLW = $clog2(N_LVL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic            bus_sel,
   input  logic            trig_wr,
   input  logic [DW-1:0]   wdata,
   output logic [N_LVL-1:0] mask_q,
   output logic [DW-1:0]   base_q,
   output logic [DW-1:0]   casc_q,
   output logic            aeoi_q,
   output logic            rsel_isr_q,
   output logic [N_LVL-1:0] trig_q,
   output logic            setup_start,
   output logic            eoi_stb,
   output logic [LVLW-1:0] eoi_lvl
);
   setup_st_e st_q;
   logic      need_casc_q, need_mode_q;
   logic      cmd_wr, dat_wr, ocw3_wr;

   initial begin
      assert (LVLW <= 3) else $error("level field exceeds command width");
      assert (N_LVL <= DW) else $error("mask wider than bus");
   end

   assign cmd_wr      = bus_wr & ~bus_sel;
   assign dat_wr      = bus_wr & bus_sel;
   assign setup_start = cmd_wr & wdata[4];
   assign ocw3_wr     = cmd_wr & ~wdata[4] & wdata[3];
   assign eoi_stb     = cmd_wr & ~wdata[4] & ~wdata[3] & (wdata[7:5] == EOI_SPECIFIC);
   assign eoi_lvl     = wdata[LVLW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= SU_IDLE;
         need_casc_q <= 1'b0;
         need_mode_q <= 1'b0;
         mask_q      <= '1;
         base_q      <= '0;
         casc_q      <= '0;
         aeoi_q      <= 1'b0;
         rsel_isr_q  <= 1'b0;
      end else if (setup_start) begin
         st_q        <= SU_BASE;
         need_casc_q <= ~wdata[1];
         need_mode_q <= wdata[0];
         rsel_isr_q  <= 1'b0;
         if (!wdata[0]) aeoi_q <= 1'b0;
      end else begin
         if (ocw3_wr && wdata[1]) rsel_isr_q <= wdata[0];
         if (dat_wr) begin
            unique case (st_q)
               SU_IDLE: mask_q <= wdata[N_LVL-1:0];
               SU_BASE: begin
                  base_q <= wdata;
                  st_q   <= need_casc_q ? SU_CASC : (need_mode_q ? SU_MODE : SU_IDLE);
               end
               SU_CASC: begin
                  casc_q <= wdata;
                  st_q   <= need_mode_q ? SU_MODE : SU_IDLE;
               end
               SU_MODE: begin
                  aeoi_q <= wdata[1];
                  st_q   <= SU_IDLE;
               end
               default: st_q <= SU_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       trig_q <= '0;
      else if (trig_wr) trig_q <= wdata[N_LVL-1:0];
   end

   AST_SETUP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && st_q != SU_IDLE) |=> $stable(mask_q)) else $error("mask hit in setup"); // R2
endmodule

// File: rtl/pic_req.sv
module pic_req #(
   parameter int N_LVL    = 8,
   parameter bit HAS_TRIG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] irq_in,
   input  logic [N_LVL-1:0] trig,
   input  logic [N_LVL-1:0] ack_clr,
   output logic [N_LVL-1:0] irr_q
);
   logic [N_LVL-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_in;
   end

   for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
      logic edge_nxt, lvl_mode;
      assign edge_nxt = (irr_q[i] & ~ack_clr[i]) | (irq_in[i] & ~prev_q[i]);
      if (HAS_TRIG) begin : g_sel
         assign lvl_mode = trig[i];
      end else begin : g_edge_only
         assign lvl_mode = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)        irr_q[i] <= 1'b0;
         else if (lvl_mode) irr_q[i] <= irq_in[i];
         else               irr_q[i] <= edge_nxt;
      end
      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_mode && irq_in[i] && !prev_q[i]) |=> irr_q[i]) else $error("edge lost"); // R12
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int DW    = 8,
   parameter int N_LVL = 8,
   localparam int LVLW = $clog2(N_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] irr,
   input  logic [N_LVL-1:0] mask,
   input  logic [DW-1:0]    base,
   input  logic             aeoi,
   input  logic             setup_start,
   input  logic             eoi_stb,
   input  logic [LVLW-1:0]  eoi_lvl,
   input  logic             ack,
   output logic [N_LVL-1:0] isr_q,
   output logic             int_req,
   output logic [N_LVL-1:0] ack_clr,
   output logic [DW-1:0]    vec_q,
   output logic             vec_vld_q
);
   localparam logic [LVLW-1:0] SPUR_LVL = LVLW'(N_LVL - 1);

   logic [N_LVL-1:0] pend, grant_1h, eoi_1h;
   logic [LVLW-1:0]  p_idx, s_idx, vec_lvl;
   logic             p_any, s_any, ack_win;

   assign pend = irr & ~mask;

   always_comb begin
      p_idx = '0;
      p_any = 1'b0;
      s_idx = '0;
      s_any = 1'b0;
      for (int i = N_LVL - 1; i >= 0; i--) begin
         if (pend[i])  begin p_idx = LVLW'(i); p_any = 1'b1; end
         if (isr_q[i]) begin s_idx = LVLW'(i); s_any = 1'b1; end
      end
   end

   assign int_req  = p_any & (~s_any | (p_idx < s_idx));
   assign ack_win  = ack & int_req;
   assign grant_1h = ack_win ? (N_LVL'(1) << p_idx) : '0;
   assign ack_clr  = grant_1h;
   assign eoi_1h   = eoi_stb ? (N_LVL'(1) << eoi_lvl) : '0;
   assign vec_lvl  = ack_win ? p_idx : SPUR_LVL;

   always_ff @(posedge clk) begin
      if (!rst_n)           isr_q <= '0;
      else if (setup_start) isr_q <= '0;
      else                  isr_q <= (isr_q & ~eoi_1h) | (aeoi ? '0 : grant_1h);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q     <= '0;
         vec_vld_q <= 1'b0;
      end else begin
         vec_vld_q <= ack;
         if (ack) vec_q <= base + DW'(vec_lvl);
      end
   end

   AST_ACK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_vld_q) else $error("no vector pulse"); // R3
   AST_AEOI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi) |=> ((isr_q & ~$past(isr_q)) == '0)) else $error("auto release set a bit"); // R5
   AST_SPUR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_req && !eoi_stb && !setup_start) |=> $stable(isr_q)) else $error("spurious touched isr"); // R9
   AST_EOI_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb && !ack && !setup_start) |=> (isr_q == ($past(isr_q) & ~(N_LVL'(1) << $past(eoi_lvl))))) else $error("eoi wrong bits"); // R8
endmodule

// File: rtl/pic_core.sv
module pic_core #(
   parameter int DW       = 8,
   parameter int N_LVL    = 8,
   parameter bit HAS_TRIG = 1'b1,
   localparam int LVLW    = $clog2(N_LVL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_sel,
   input  logic          trig_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [N_LVL-1:0] irq_line,
   input  logic          inta,
   output logic          int_out,
   output logic [DW-1:0] vec_out,
   output logic          vec_valid,
   output logic [DW-1:0] cascade_cfg
);
   logic [N_LVL-1:0] mask, trig, irr, isr, ack_clr;
   logic [DW-1:0]    base, casc;
   logic             aeoi, rsel_isr, setup_start, eoi_stb;
   logic [LVLW-1:0]  eoi_lvl;

   initial begin
      assert (N_LVL == DW) else $error("level count must match bus width");
      assert ((1 << LVLW) == N_LVL) else $error("level count must be a power of two");
   end

   pic_regs #(.DW(DW), .N_LVL(N_LVL)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .trig_wr(trig_wr), .wdata(wdata), .mask_q(mask), .base_q(base),
      .casc_q(casc), .aeoi_q(aeoi), .rsel_isr_q(rsel_isr), .trig_q(trig),
      .setup_start(setup_start), .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl)
   );

   pic_req #(.N_LVL(N_LVL), .HAS_TRIG(HAS_TRIG)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_line), .trig(trig),
      .ack_clr(ack_clr), .irr_q(irr)
   );

   pic_prio #(.DW(DW), .N_LVL(N_LVL)) u_prio (
      .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .base(base),
      .aeoi(aeoi), .setup_start(setup_start), .eoi_stb(eoi_stb),
      .eoi_lvl(eoi_lvl), .ack(inta), .isr_q(isr), .int_req(int_out),
      .ack_clr(ack_clr), .vec_q(vec_out), .vec_vld_q(vec_valid)
   );

   assign rdata       = bus_sel ? DW'(mask) : (rsel_isr ? DW'(isr) : DW'(irr));
   assign cascade_cfg = casc;

   AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |-> !int_out) else $error("output with full mask"); // R6
   AST_NO_OUT_UNDER_ISR0: assert property (@(posedge clk) disable iff (!rst_n)
      isr[0] |-> !int_out) else $error("outranked level raised output"); // R10
endmodule

// File: tb/sim_pic_core.sv
module sim_pic_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_sel = 1'b0, trig_wr = 1'b0, inta = 1'b0;
   logic [7:0] wdata = '0, irq_line = '0;
   logic [7:0] rdata, vec_out, cascade_cfg;
   logic       int_out, vec_valid;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   pic_core u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .trig_wr(trig_wr), .wdata(wdata), .rdata(rdata), .irq_line(irq_line),
      .inta(inta), .int_out(int_out), .vec_out(vec_out),
      .vec_valid(vec_valid), .cascade_cfg(cascade_cfg)
   );

   always #10 clk = ~clk;

   // behavioural reference model
   logic [7:0] m_irr, m_isr, m_mask, m_base, m_casc, m_trig, m_prev, m_vec;
   logic       m_aeoi, m_rsel, m_vv, m_ncasc, m_nmode;
   int         m_stage;

   function automatic int first_of(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic bit m_int();
      int p = first_of(m_irr & ~m_mask);
      int s = first_of(m_isr);
      return (p < 8) && (p < s);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 0; m_casc = 0;
         m_trig = 0; m_prev = 0; m_vec = 0; m_aeoi = 0; m_rsel = 0;
         m_vv = 0; m_stage = 0; m_ncasc = 0; m_nmode = 0;
      end else begin
         automatic logic [7:0] n_irr, n_isr, clr;
         automatic int p = first_of(m_irr & ~m_mask);
         automatic bit win = m_int();
         automatic bit start = bus_wr && !bus_sel && wdata[4];
         clr = 0;
         n_isr = m_isr;
         if (bus_wr && !bus_sel && wdata[7:3] == 5'b01100) n_isr[wdata[2:0]] = 1'b0;
         m_vv = inta;
         if (inta) begin
            if (win) begin
               m_vec = m_base + 8'(p);
               clr[p] = 1'b1;
               if (!m_aeoi) n_isr[p] = 1'b1;
            end else m_vec = m_base + 8'd7;
         end
         if (start) n_isr = 0;
         for (int i = 0; i < 8; i++)
            n_irr[i] = m_trig[i] ? irq_line[i]
                     : ((m_irr[i] && !clr[i]) || (irq_line[i] && !m_prev[i]));
         m_prev = irq_line;
         if (trig_wr) m_trig = wdata;
         if (start) begin
            m_stage = 1; m_ncasc = !wdata[1]; m_nmode = wdata[0]; m_rsel = 0;
            if (!wdata[0]) m_aeoi = 0;
         end else begin
            if (bus_wr && !bus_sel && wdata[3] && wdata[1]) m_rsel = wdata[0];
            if (bus_wr && bus_sel) begin
               case (m_stage)
                  0: m_mask = wdata;
                  1: begin m_base = wdata; m_stage = m_ncasc ? 2 : (m_nmode ? 3 : 0); end
                  2: begin m_casc = wdata; m_stage = m_nmode ? 3 : 0; end
                  default: begin m_aeoi = wdata[1]; m_stage = 0; end
               endcase
            end
         end
         m_irr = n_irr;
         m_isr = n_isr;
      end
   end

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R10 int_out", 8'(int_out), 8'(m_int()));
         check("R3 vec_valid", 8'(vec_valid), 8'(m_vv));
         if (m_vv) check("R3 vec_out", vec_out, m_vec);
         check("R4 cascade", cascade_cfg, m_casc);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wr(logic sel, logic [7:0] d);
      @(negedge clk); bus_wr = 1; bus_sel = sel; wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic twr(logic [7:0] d);
      @(negedge clk); trig_wr = 1; wdata = d;
      @(negedge clk); trig_wr = 0;
   endtask

   task automatic ack();
      @(negedge clk); inta = 1;
      @(negedge clk); inta = 0;
   endtask

   task automatic ack_eoi(logic [7:0] c);
      @(negedge clk); inta = 1; bus_wr = 1; bus_sel = 0; wdata = c;
      @(negedge clk); inta = 0; bus_wr = 0;
   endtask

   task automatic rd(string req, logic sel, logic [7:0] exp);
      @(negedge clk); bus_sel = sel; #2;
      check(req, rdata, exp);
   endtask

   task automatic set_irq(logic [7:0] v);
      @(negedge clk); irq_line = v;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1;
      rd("R1 mask after reset", 1, 8'hFF);
      rd("R1 cmd read after reset", 0, 8'h00);
      check("R1 int_out", 8'(int_out), 8'h00);
      check("R1 cascade", cascade_cfg, 8'h00);

      // setup: base 0x20, cascade 0x04, mode word without auto release
      wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
      check("R4 cascade stored", cascade_cfg, 8'h04);
      rd("R2 mask untouched by setup words", 1, 8'hFF);
      wr(1, 8'h00);
      rd("R6 mask readback", 1, 8'h00);

      // edge request on level 3
      set_irq(8'h08); set_irq(8'h00);
      wr(0, 8'h0A);
      rd("R12 edge held", 0, 8'h08);
      check("R10 output up", 8'(int_out), 8'h01);
      ack();
      check("R3 vector level3", vec_out, 8'h23);
      wr(0, 8'h0B);
      rd("R11 isr set", 0, 8'h08);
      rd("R7 isr select persists", 0, 8'h08);
      wr(0, 8'h0A);
      rd("R11 edge request cleared", 0, 8'h00);

      // lower then higher priority while level 3 in service
      set_irq(8'h20);
      check("R10 level5 below service", 8'(int_out), 8'h00);
      set_irq(8'h22);
      check("R10 level1 above service", 8'(int_out), 8'h01);
      ack();
      check("R3 vector level1", vec_out, 8'h21);
      wr(0, 8'h0B);
      rd("R11 two in service", 0, 8'h0A);
      wr(0, 8'h61);
      rd("R8 only level1 cleared", 0, 8'h08);
      wr(0, 8'h63);
      check("R10 level5 now wins", 8'(int_out), 8'h01);
      ack();
      check("R3 vector level5", vec_out, 8'h25);
      wr(0, 8'h65);
      set_irq(8'h00);

      // level-sensitive level 4, spurious with level 7 masked
      wr(1, 8'h80);
      twr(8'h10);
      set_irq(8'h10);
      wr(0, 8'h0A);
      rd("R13 level follows high", 0, 8'h10);
      set_irq(8'h00);
      rd("R13 level follows low", 0, 8'h00);
      ack();
      check("R9 spurious vector", vec_out, 8'h27);
      wr(0, 8'h0B);
      rd("R9 isr untouched", 0, 8'h00);
      set_irq(8'h10);
      ack();
      check("R3 vector level4", vec_out, 8'h24);
      rd("R11 level4 in service", 0, 8'h10);
      wr(0, 8'h0A);
      rd("R13 ack keeps level request", 0, 8'h10);
      set_irq(8'h00);
      wr(0, 8'h64);
      twr(8'h00);

      // acknowledge and EOI in the same cycle
      set_irq(8'h08); set_irq(8'h00);
      ack();
      set_irq(8'h02); set_irq(8'h00);
      ack_eoi(8'h63);
      check("R3 vector collision", vec_out, 8'h21);
      wr(0, 8'h0B);
      rd("R8 R11 collision result", 0, 8'h02);
      wr(0, 8'h61);

      // full mask
      wr(1, 8'hFF);
      set_irq(8'h01); set_irq(8'h00);
      check("R6 full mask quiet", 8'(int_out), 8'h00);
      wr(1, 8'h00);
      check("R6 unmask raises", 8'(int_out), 8'h01);
      ack();
      check("R3 vector level0", vec_out, 8'h20);

      // new setup: single (no cascade word), mode word with auto release
      wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h02);
      check("R4 cascade kept when skipped", cascade_cfg, 8'h04);
      wr(0, 8'h0B);
      rd("R2 setup cleared isr", 0, 8'h00);
      rd("R2 mask unchanged", 1, 8'h00);
      set_irq(8'h04); set_irq(8'h00);
      ack();
      check("R3 vector new base", vec_out, 8'h42);
      rd("R5 no isr with auto release", 0, 8'h00);
      check("R5 output low after", 8'(int_out), 8'h00);
      idle(3);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule